// File: doc/BRIEF.md
# NAND Device Command Sequence Decoder

This block sits on the device side of an 8-bit multiplexed NAND flash bus and turns the strobe traffic into decoded operations. It samples the bus on every rising edge of the write strobe while the chip select is low. It sorts each sampled byte into a command byte, an address byte or a data byte, and follows the command sequences the device accepts. When a sequence completes, it emits a one-cycle operation pulse together with the column and row address that was collected.

Each setup command expects its own number of address bytes. Reads, programs and copy-back programs take two column bytes followed by two row bytes. Erase takes the two row bytes only. Inside an open program sequence, a random-data-input command takes two fresh column bytes. While the array reports busy, only status read and reset get through. Every other command, every undefined code, every out-of-place confirm and every address byte that is not expected raises a one-cycle error pulse and drops the decoder back to idle without starting anything.

Downstream, the operation pulse starts the array controller, and the status-read pulse selects the status byte for the next read cycle.

Top module: `nand_cmd_decoder`

## Requirements
- R1: A byte is taken only when `we_n` rises while `ce_n` is low. `cle`=1 with `ale`=0 marks a command byte and `ale`=1 with `cle`=0 marks an address byte. Any other combination is a data byte and never produces an operation, error or status pulse on its own. With `ce_n` high, nothing is taken.
- R2: The sequence 00h, four address bytes, 30h issues operation code 1 (page read). The sequence 00h, four address bytes, 35h issues code 2 (read for copy-back). Address bytes arrive column low, column high, row low, row high, and `col_o`/`row_o` carry them as 16-bit values.
- R3: The sequence 80h, four address bytes, any number of data bytes, 10h issues code 3 (page program). Ending the same sequence with 15h issues code 4 (cache program).
- R4: From idle, the sequence 85h, four address bytes, 10h issues code 5 (copy-back program).
- R5: The sequence 60h, two address bytes, D0h issues code 6 (block erase). The two bytes form `row_o` (low byte first) and `col_o` reports 0.
- R6: FFh issues code 7 (reset) and 90h issues code 8 (read ID) at once. 70h produces a `stat_req_o` pulse and no operation pulse.
- R7: A command byte outside {00h, 10h, 15h, 30h, 35h, 60h, 70h, 80h, 85h, 90h, D0h, FFh} raises `err_o` and issues no operation.
- R8: While `busy_i` is high in the cycle a command byte is decoded, 70h and FFh are accepted as normal. Any other command raises `err_o`, issues nothing and returns the decoder to idle.
- R9: A confirm byte that does not belong to the open setup command, a confirm that arrives before all address bytes, or an address byte that is not expected raises `err_o` and returns the decoder to idle.
- R10: Inside an open program sequence (after all four address bytes), 85h followed by two address bytes replaces only the column. The row is kept, and the final program reports the new column.
- R11: FFh received inside a partly received sequence issues reset and leaves the decoder idle, so a following confirm byte is an error.
- R12: A 70h received inside an open sequence gives a status pulse and leaves that sequence able to complete.
- R13: `op_valid_o`, `err_o` and `stat_req_o` are single-cycle pulses, and at most one of them is high in any cycle. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| cle | input | 1 | High marks a command byte |
| ale | input | 1 | High marks an address byte |
| we_n | input | 1 | Write strobe; a byte is taken on its rising edge |
| io | input | 8 | Bus byte |
| busy_i | input | 1 | Array busy level |
| op_valid_o | output | 1 | One-cycle pulse: a decoded operation is issued |
| op_code_o | output | 4 | Operation code (1 read, 2 read for copy-back, 3 program, 4 cache program, 5 copy-back program, 6 erase, 7 reset, 8 read ID) |
| col_o | output | 16 | Column address of the issued operation |
| row_o | output | 16 | Row address of the issued operation |
| err_o | output | 1 | One-cycle pulse: rejected byte or sequence |
| stat_req_o | output | 1 | One-cycle pulse: status read requested |

## Verification
The busy level and the decoding of a command byte meet in the same cycle. That cycle decides whether a confirm starts an operation or is rejected. The bench drives a read sequence and changes `busy_i` on the same half cycle in which `we_n` returns high for the final 30h. With busy raised there, exactly one error pulse and no operation must follow. With busy dropped there, the read must be issued with its address. A status read placed inside an open sequence is judged the same way: it must give one status pulse and leave the sequence able to complete.

// File: rtl/nand_dec_pkg.sv
package nand_dec_pkg;

  typedef enum logic [3:0] {
    OP_NONE       = 4'd0,
    OP_READ       = 4'd1,
    OP_READ_CB    = 4'd2,
    OP_PROG       = 4'd3,
    OP_CACHE_PROG = 4'd4,
    OP_COPY_PROG  = 4'd5,
    OP_ERASE      = 4'd6,
    OP_RESET      = 4'd7,
    OP_IDENT      = 4'd8
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CONF,
    ST_PDATA,
    ST_RCOL
  } seq_st_e;

  typedef enum logic [1:0] {
    K_RD,
    K_PG,
    K_CB,
    K_ER
  } seq_kind_e;

  localparam logic [7:0] C_RD_SETUP  = 8'h00;
  localparam logic [7:0] C_RD_GO     = 8'h30;
  localparam logic [7:0] C_RD_CB_GO  = 8'h35;
  localparam logic [7:0] C_PG_SETUP  = 8'h80;
  localparam logic [7:0] C_PG_GO     = 8'h10;
  localparam logic [7:0] C_PG_CACHE  = 8'h15;
  localparam logic [7:0] C_MOVE      = 8'h85;
  localparam logic [7:0] C_ER_SETUP  = 8'h60;
  localparam logic [7:0] C_ER_GO     = 8'hD0;
  localparam logic [7:0] C_RESET     = 8'hFF;
  localparam logic [7:0] C_STATUS    = 8'h70;
  localparam logic [7:0] C_IDENT     = 8'h90;

endpackage

// File: rtl/nand_bus_sampler.sv
module nand_bus_sampler #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          cle,
  input  logic          ale,
  input  logic          we_n,
  input  logic [DW-1:0] io,
  output logic          cmd_stb,
  output logic          adr_stb,
  output logic [DW-1:0] byte_o
);

  logic          r_we, r_we_d, r_ce, r_cle, r_ale;
  logic [DW-1:0] r_io;
  logic          rise;

  assign rise = r_we & ~r_we_d & ~r_ce;

  always_ff @(posedge clk) begin
    if (rst) begin
      r_we    <= 1'b1;
      r_we_d  <= 1'b1;
      r_ce    <= 1'b1;
      r_cle   <= 1'b0;
      r_ale   <= 1'b0;
      r_io    <= '0;
      cmd_stb <= 1'b0;
      adr_stb <= 1'b0;
      byte_o  <= '0;
    end else begin
      r_we    <= we_n;
      r_we_d  <= r_we;
      r_ce    <= ce_n;
      r_cle   <= cle;
      r_ale   <= ale;
      r_io    <= io;
      cmd_stb <= rise & r_cle & ~r_ale;
      adr_stb <= rise & r_ale & ~r_cle;
      if (rise) byte_o <= r_io;
    end
  end

endmodule

// File: rtl/nand_addr_asm.sv
module nand_addr_asm #(
  parameter  int COL_BYTES = 2,
  parameter  int ROW_BYTES = 2,
  localparam int NS        = COL_BYTES + ROW_BYTES,
  localparam int SW        = $clog2(NS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   wr,
  input  logic [SW-1:0]          slot,
  input  logic [7:0]             din,
  output logic [8*COL_BYTES-1:0] col,
  output logic [8*ROW_BYTES-1:0] row
);

  logic [8*NS-1:0] flat;

  for (genvar g = 0; g < NS; g++) begin : g_slot
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (rst || clr)                     q <= '0;
      else if (wr && slot == SW'(g))      q <= din;
    end
    assign flat[8*g +: 8] = q;
  end

  assign col = flat[8*COL_BYTES-1:0];
  assign row = flat[8*NS-1:8*COL_BYTES];

endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
  import nand_dec_pkg::*;
#(
  parameter  int COL_BYTES = 2,
  parameter  int ROW_BYTES = 2,
  localparam int NS        = COL_BYTES + ROW_BYTES,
  localparam int SW        = $clog2(NS),
  localparam int CW        = $clog2(NS + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   busy,
  input  logic                   cmd_stb,
  input  logic                   adr_stb,
  input  logic [7:0]             byte_i,
  input  logic [8*COL_BYTES-1:0] col_i,
  input  logic [8*ROW_BYTES-1:0] row_i,
  output logic                   a_clr,
  output logic                   a_wr,
  output logic [SW-1:0]          a_slot,
  output logic                   op_valid_o,
  output logic [3:0]             op_code_o,
  output logic [8*COL_BYTES-1:0] col_o,
  output logic [8*ROW_BYTES-1:0] row_o,
  output logic                   err_o,
  output logic                   stat_o
);

  localparam logic [CW-1:0] N_ALL = CW'(NS);
  localparam logic [CW-1:0] N_ROW = CW'(ROW_BYTES);
  localparam logic [CW-1:0] N_COL = CW'(COL_BYTES);
  localparam logic [CW-1:0] B_ROW = CW'(COL_BYTES);

  seq_st_e   st_q, st_n;
  seq_kind_e kind_q, kind_n;
  logic [CW-1:0] cnt_q, cnt_n, need_c, base_c;
  logic iss, err_n, stat_n;
  op_e  iss_op;

  always_comb begin
    if (st_q == ST_RCOL) begin
      need_c = N_COL;
      base_c = '0;
    end else if (kind_q == K_ER) begin
      need_c = N_ROW;
      base_c = B_ROW;
    end else begin
      need_c = N_ALL;
      base_c = '0;
    end
  end

  assign a_slot = SW'(base_c + cnt_q);

  always_comb begin
    st_n   = st_q;
    kind_n = kind_q;
    cnt_n  = cnt_q;
    iss    = 1'b0;
    iss_op = OP_NONE;
    err_n  = 1'b0;
    stat_n = 1'b0;
    a_clr  = 1'b0;
    a_wr   = 1'b0;
    if (cmd_stb) begin
      if (byte_i == C_RESET) begin
        iss    = 1'b1;
        iss_op = OP_RESET;
        st_n   = ST_IDLE;
      end else if (byte_i == C_STATUS) begin
        stat_n = 1'b1;
      end else if (busy) begin
        err_n = 1'b1;
        st_n  = ST_IDLE;
      end else begin
        st_n = ST_IDLE;
        case (st_q)
          ST_IDLE: begin
            cnt_n = '0;
            case (byte_i)
              C_RD_SETUP: begin st_n = ST_ADDR; kind_n = K_RD; a_clr = 1'b1; end
              C_PG_SETUP: begin st_n = ST_ADDR; kind_n = K_PG; a_clr = 1'b1; end
              C_MOVE:     begin st_n = ST_ADDR; kind_n = K_CB; a_clr = 1'b1; end
              C_ER_SETUP: begin st_n = ST_ADDR; kind_n = K_ER; a_clr = 1'b1; end
              C_IDENT:    begin iss = 1'b1; iss_op = OP_IDENT; end
              default:    err_n = 1'b1;
            endcase
          end
          ST_CONF: begin
            if (kind_q == K_RD && byte_i == C_RD_GO) begin
              iss = 1'b1; iss_op = OP_READ;
            end else if (kind_q == K_RD && byte_i == C_RD_CB_GO) begin
              iss = 1'b1; iss_op = OP_READ_CB;
            end else if (kind_q == K_CB && byte_i == C_PG_GO) begin
              iss = 1'b1; iss_op = OP_COPY_PROG;
            end else if (kind_q == K_ER && byte_i == C_ER_GO) begin
              iss = 1'b1; iss_op = OP_ERASE;
            end else begin
              err_n = 1'b1;
            end
          end
          ST_PDATA: begin
            if (byte_i == C_PG_GO) begin
              iss = 1'b1; iss_op = OP_PROG;
            end else if (byte_i == C_PG_CACHE) begin
              iss = 1'b1; iss_op = OP_CACHE_PROG;
            end else if (byte_i == C_MOVE) begin
              st_n  = ST_RCOL;
              cnt_n = '0;
            end else begin
              err_n = 1'b1;
            end
          end
          default: err_n = 1'b1;
        endcase
      end
    end else if (adr_stb) begin
      if (st_q == ST_ADDR || st_q == ST_RCOL) begin
        a_wr  = 1'b1;
        cnt_n = CW'(cnt_q + 1'b1);
        if (cnt_q == CW'(need_c - 1'b1)) begin
          cnt_n = '0;
          st_n  = (st_q == ST_RCOL || kind_q == K_PG) ? ST_PDATA : ST_CONF;
        end
      end else begin
        err_n = 1'b1;
        st_n  = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      kind_q     <= K_RD;
      cnt_q      <= '0;
      op_valid_o <= 1'b0;
      op_code_o  <= OP_NONE;
      col_o      <= '0;
      row_o      <= '0;
      err_o      <= 1'b0;
      stat_o     <= 1'b0;
    end else begin
      st_q       <= st_n;
      kind_q     <= kind_n;
      cnt_q      <= cnt_n;
      op_valid_o <= iss;
      err_o      <= err_n;
      stat_o     <= stat_n;
      if (iss) begin
        op_code_o <= iss_op;
        col_o     <= col_i;
        row_o     <= row_i;
      end
    end
  end

endmodule

// File: rtl/nand_cmd_decoder.sv
module nand_cmd_decoder #(
  parameter  int COL_BYTES = 2,
  parameter  int ROW_BYTES = 2,
  localparam int SW        = $clog2(COL_BYTES + ROW_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ce_n,
  input  logic                   cle,
  input  logic                   ale,
  input  logic                   we_n,
  input  logic [7:0]             io,
  input  logic                   busy_i,
  output logic                   op_valid_o,
  output logic [3:0]             op_code_o,
  output logic [8*COL_BYTES-1:0] col_o,
  output logic [8*ROW_BYTES-1:0] row_o,
  output logic                   err_o,
  output logic                   stat_req_o
);

  logic                   cmd_stb, adr_stb;
  logic [7:0]             bus_byte;
  logic                   a_clr, a_wr;
  logic [SW-1:0]          a_slot;
  logic [8*COL_BYTES-1:0] asm_col;
  logic [8*ROW_BYTES-1:0] asm_row;

  nand_bus_sampler #(.DW(8)) u_smp (
    .clk     (clk),
    .rst     (rst),
    .ce_n    (ce_n),
    .cle     (cle),
    .ale     (ale),
    .we_n    (we_n),
    .io      (io),
    .cmd_stb (cmd_stb),
    .adr_stb (adr_stb),
    .byte_o  (bus_byte)
  );

  nand_addr_asm #(.COL_BYTES(COL_BYTES), .ROW_BYTES(ROW_BYTES)) u_asm (
    .clk  (clk),
    .rst  (rst),
    .clr  (a_clr),
    .wr   (a_wr),
    .slot (a_slot),
    .din  (bus_byte),
    .col  (asm_col),
    .row  (asm_row)
  );

  nand_seq_fsm #(.COL_BYTES(COL_BYTES), .ROW_BYTES(ROW_BYTES)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy_i),
    .cmd_stb    (cmd_stb),
    .adr_stb    (adr_stb),
    .byte_i     (bus_byte),
    .col_i      (asm_col),
    .row_i      (asm_row),
    .a_clr      (a_clr),
    .a_wr       (a_wr),
    .a_slot     (a_slot),
    .op_valid_o (op_valid_o),
    .op_code_o  (op_code_o),
    .col_o      (col_o),
    .row_o      (row_o),
    .err_o      (err_o),
    .stat_o     (stat_req_o)
  );

endmodule

// File: rtl/nand_cmd_decoder_chk.sv
module nand_cmd_decoder_chk #(
  parameter int COL_BYTES = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   busy_i,
  input logic                   op_valid_o,
  input logic [3:0]             op_code_o,
  input logic [8*COL_BYTES-1:0] col_o,
  input logic                   err_o,
  input logic                   stat_req_o
);

  AST_OP_NOT_ERR: assert property (@(posedge clk) disable iff (rst)
    op_valid_o |-> !err_o); // R7

  AST_OP_PULSE: assert property (@(posedge clk) disable iff (rst)
    op_valid_o |=> !op_valid_o); // R13

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
    err_o |=> !err_o); // R13

  AST_STAT_ALONE: assert property (@(posedge clk) disable iff (rst)
    stat_req_o |-> (!op_valid_o && !err_o)); // R6

  AST_BUSY_GATE: assert property (@(posedge clk) disable iff (rst)
    (op_valid_o && op_code_o != 4'd7) |-> !$past(busy_i)); // R8

  AST_ERASE_COL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (op_valid_o && op_code_o == 4'd6) |-> col_o == '0); // R5

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    op_valid_o |-> (op_code_o != 4'd0 && op_code_o <= 4'd8)); // R2

endmodule

bind nand_cmd_decoder nand_cmd_decoder_chk #(.COL_BYTES(COL_BYTES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy_i     (busy_i),
  .op_valid_o (op_valid_o),
  .op_code_o  (op_code_o),
  .col_o      (col_o),
  .err_o      (err_o),
  .stat_req_o (stat_req_o)
);

// File: tb/nand_cmd_decoder_tb.sv
`timescale 1ns/1ps
module nand_cmd_decoder_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, busy = 1'b0;
  logic [7:0]  io = '0;
  logic        op_valid, err, stat;
  logic [3:0]  op_code;
  logic [15:0] col, row;

  always #4 clk = ~clk;

  nand_cmd_decoder u_dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .io(io), .busy_i(busy), .op_valid_o(op_valid), .op_code_o(op_code),
    .col_o(col), .row_o(row), .err_o(err), .stat_req_o(stat)
  );

  int n_op = 0, n_err = 0, n_stat = 0;
  int last_op = 0, last_col = 0, last_row = 0;
  int o_op, o_err, o_stat;
  int total = 0, bad = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (op_valid) begin
        n_op++; last_op = int'(op_code); last_col = int'(col); last_row = int'(row);
      end
      if (err)  n_err++;
      if (stat) n_stat++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic c, input logic a, input logic [7:0] v);
    @(negedge clk);
    cle = c; ale = a; io = v; we_n = 1'b0;
    repeat (2) @(negedge clk);
    we_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] v); put(1'b1, 1'b0, v); endtask
  task automatic adr(input logic [7:0] v); put(1'b0, 1'b1, v); endtask
  task automatic dat(input logic [7:0] v); put(1'b0, 1'b0, v); endtask

  task automatic adr4(input int cv, input int rv);
    adr(8'(cv)); adr(8'(cv >> 8)); adr(8'(rv)); adr(8'(rv >> 8));
  endtask

  task automatic mark;
    repeat (4) @(negedge clk);
    o_op = n_op; o_err = n_err; o_stat = n_stat;
  endtask

  // compares pulse-count deltas (op*100 + err*10 + stat) and, when asked, code and address
  task automatic expect_d(input string req, input int dop, input int derr, input int dstat,
                          input int opc, input bit chkad, input int cv, input int rv);
    int a, e;
    repeat (4) @(negedge clk);
    a = (n_op - o_op) * 100 + (n_err - o_err) * 10 + (n_stat - o_stat);
    e = dop * 100 + derr * 10 + dstat;
    chk(a == e, req, a, e);
    if (dop > 0 && opc >= 0) chk(last_op == opc, req, last_op, opc);
    if (chkad) begin
      chk(last_col == cv, req, last_col, cv);
      chk(last_row == rv, req, last_row, rv);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    ce_n = 1'b0;
    @(negedge clk);
    // R13: reset state
    chk({op_valid, err, stat} == 3'b000, "R13", int'({op_valid, err, stat}), 0);
    chk(op_code == 4'd0 && col == 16'd0 && row == 16'd0, "R13", int'(op_code), 0);

    // R6 / R7: sweep every command code from idle
    for (int c = 0; c < 256; c++) begin
      logic [7:0] cb;
      int dop, derr, dst, opc;
      bit opens;
      cb = 8'(c);
      opens = (c == 'h00) || (c == 'h80) || (c == 'h85) || (c == 'h60);
      dop = 0; derr = 0; dst = 0; opc = -1;
      if (c == 'hFF)      begin dop = 1; opc = 7; end
      else if (c == 'h90) begin dop = 1; opc = 8; end
      else if (c == 'h70) dst = 1;
      else if (!opens)    derr = 1;
      mark;
      cmd(cb);
      expect_d((c == 'hFF || c == 'h90 || c == 'h70) ? "R6" : "R7", dop, derr, dst, opc, 0, 0, 0);
      if (opens) cmd(8'hFF);
    end

    // R2 / R9: sweep every confirm code after a full read setup
    for (int c = 0; c < 256; c++) begin
      logic [7:0] cb;
      int cv, rv, dop, derr, dst, opc;
      cb = 8'(c);
      cv = (((c ^ 'h5A) & 255) << 8) | c;
      rv = ((~c & 255) << 8) | ((c + 1) & 255);
      dop = 0; derr = 0; dst = 0; opc = -1;
      if (c == 'h30)      begin dop = 1; opc = 1; end
      else if (c == 'h35) begin dop = 1; opc = 2; end
      else if (c == 'hFF) begin dop = 1; opc = 7; end
      else if (c == 'h70) dst = 1;
      else                derr = 1;
      mark;
      cmd(8'h00);
      adr4(cv, rv);
      cmd(cb);
      expect_d((c == 'h30 || c == 'h35) ? "R2" : "R9", dop, derr, dst, opc,
               (c == 'h30 || c == 'h35), cv, rv);
      if (c == 'h70) cmd(8'hFF);
    end

    // R3: program and cache program with data bytes
    mark; cmd(8'h80); adr4('h1234, 'hBEEF);
    for (int i = 0; i < 5; i++) dat(8'(i * 37));
    cmd(8'h10);
    expect_d("R3", 1, 0, 0, 3, 1, 'h1234, 'hBEEF);
    mark; cmd(8'h80); adr4('h0042, 'h7001); dat(8'hAA); cmd(8'h15);
    expect_d("R3", 1, 0, 0, 4, 1, 'h0042, 'h7001);

    // R4: copy-back program; wrong confirm after copy-back setup is R9
    mark; cmd(8'h85); adr4('h0800, 'h0321); cmd(8'h10);
    expect_d("R4", 1, 0, 0, 5, 1, 'h0800, 'h0321);
    mark; cmd(8'h85); adr4('h0800, 'h0321); cmd(8'h30);
    expect_d("R9", 0, 1, 0, -1, 0, 0, 0);

    // R5: erase takes two row bytes, column reported as 0
    mark; cmd(8'h60); adr(8'h9C); adr(8'h03); cmd(8'hD0);
    expect_d("R5", 1, 0, 0, 6, 1, 0, 'h039C);
    // R9: third row byte is unexpected, then D0 lands in idle
    mark; cmd(8'h60); adr(8'h01); adr(8'h02); adr(8'h03); cmd(8'hD0);
    expect_d("R9", 0, 2, 0, -1, 0, 0, 0);
    // R9: confirm before all address bytes
    mark; cmd(8'h00); adr(8'h11); adr(8'h22); cmd(8'h30);
    expect_d("R9", 0, 1, 0, -1, 0, 0, 0);
    // R9: address byte in idle
    mark; adr(8'h55);
    expect_d("R9", 0, 1, 0, -1, 0, 0, 0);

    // R10: random data input replaces the column only
    mark; cmd(8'h80); adr4('h0123, 'h4567); dat(8'h01);
    cmd(8'h85); adr(8'h89); adr(8'h07); dat(8'h02); cmd(8'h10);
    expect_d("R10", 1, 0, 0, 3, 1, 'h0789, 'h4567);
    mark; cmd(8'h80); adr4('h0123, 'h4567); cmd(8'h85); adr(8'h89); cmd(8'h10);
    expect_d("R10", 0, 1, 0, -1, 0, 0, 0);

    // R11: reset aborts a partial sequence
    mark; cmd(8'h00); adr(8'h10); adr(8'h20); cmd(8'hFF); cmd(8'h30);
    expect_d("R11", 1, 1, 0, 7, 0, 0, 0);

    // R12: status read inside an open sequence
    mark; cmd(8'h00); adr4('h0A0B, 'h0C0D); cmd(8'h70); cmd(8'h30);
    expect_d("R12", 1, 0, 1, 1, 1, 'h0A0B, 'h0C0D);

    // R1: chip select high, data-marked and double-marked bytes are not taken
    mark; ce_n = 1'b1; cmd(8'h00); adr4('h1111, 'h2222); cmd(8'h30); cmd(8'h05); ce_n = 1'b0;
    expect_d("R1", 0, 0, 0, -1, 0, 0, 0);
    mark; dat(8'h30); dat(8'hFF); put(1'b1, 1'b1, 8'h90); put(1'b1, 1'b1, 8'h05);
    expect_d("R1", 0, 0, 0, -1, 0, 0, 0);

    // R8: busy accepts only status and reset
    busy = 1'b1;
    mark; cmd(8'h70);
    expect_d("R8", 0, 0, 1, -1, 0, 0, 0);
    mark; cmd(8'hFF);
    expect_d("R8", 1, 0, 0, 7, 0, 0, 0);
    mark; cmd(8'h00); cmd(8'h90); cmd(8'h60);
    expect_d("R8", 0, 3, 0, -1, 0, 0, 0);
    busy = 1'b0;

    // R8: busy rises as the confirm strobe returns high
    mark; cmd(8'h00); adr4('h0102, 'h0304);
    @(negedge clk); cle = 1'b1; ale = 1'b0; io = 8'h30; we_n = 1'b0;
    repeat (2) @(negedge clk); we_n = 1'b1; busy = 1'b1;
    repeat (2) @(negedge clk);
    expect_d("R8", 0, 1, 0, -1, 0, 0, 0);
    // R8: busy falls as the confirm strobe returns high
    mark; cmd(8'hFF); busy = 1'b0; cmd(8'h00); adr4('h0506, 'h0708); busy = 1'b1;
    @(negedge clk); cle = 1'b1; ale = 1'b0; io = 8'h30; we_n = 1'b0;
    repeat (2) @(negedge clk); we_n = 1'b1; busy = 1'b0;
    repeat (2) @(negedge clk);
    expect_d("R8", 2, 0, 0, 1, 1, 'h0506, 'h0708);

    // R6: read ID from idle
    mark; cmd(8'h90);
    expect_d("R6", 1, 0, 0, 8, 0, 0, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule